// File: doc/BRIEF.md
# I2C Master Status and Interrupt Unit

This block gathers the event strobes produced by an I2C master engine and its bus monitor and folds them into a 16-bit status word together with a single interrupt line. The master engine reports start and stop conditions, address and data NACKs, lost arbitration, finished transfers and receive FIFO pushes. It also supplies its current activity level, the transmit FIFO occupancy and a flag for an address sent with the write direction. Software reads the word through a one-cycle read port and picks which sources may raise the interrupt.

Most event bits are one-cycle images of their cause. The bus-busy bit follows start and stop conditions. The transfer-complete bit is sticky until a write-one-to-clear strobe. The transmit-request bit is armed by an address-plus-write and then reports a nearly empty transmit FIFO. Every bit is registered, so the read data and the interrupt reflect the inputs of the previous clock edge.

Top module: `i2cm_status_unit`

## Requirements
- R1: After reset the read data and the interrupt are 0, and bits 15:11 of the status word always read 0.
- R2: Bit 10 (bus busy) becomes 1 after a start strobe and 0 after a stop strobe without a start. When both strobes come in the same cycle, start wins. Otherwise the bit holds.
- R3: Bit 9 (receive overflow) is 1 for exactly the cycle after a receive push made while the receive FIFO is full, and 0 otherwise.
- R4: Bit 8 (transfer complete) sets on the transfer-done strobe and holds until the done_clr strobe. A set and a clear in the same cycle leave it at 1.
- R5: Bit 7 mirrors a data NACK strobe and bit 4 mirrors an address NACK strobe, each for one cycle.
- R6: Bit 6 (master busy) is 1 when the engine is active and arbitration is not lost in that cycle, and 0 otherwise.
- R7: Bit 5 (arbitration lost) mirrors the arbitration-lost strobe for one cycle.
- R8: Bit 3 (receive request) is 1 for the cycle after each receive push, whether or not the FIFO is full.
- R9: Bit 2 (transmit request) is 1 while the transmit FIFO holds 0 or 1 byte, but only once an address-plus-write has been sent. A start or stop strobe disarms it, and an address-plus-write wins over a start or stop in the same cycle. It is 0 when not armed.
- R10: Bits 1:0 encode transmit occupancy: 00 for empty, 11 for full (TX_DEPTH bytes), 01 for any level in between. The code 10 never appears.
- R11: irq is 1 when any enabled source is set. The enable bits are: bit 0 for transfer complete, bit 1 for both NACK bits, bit 2 for arbitration lost, bit 3 for receive request and bit 4 for transmit request. irq is registered one cycle after the status.
- R12: rd_data loads the status word on each cycle with rd_en high and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | Start condition seen on the bus |
| stop_det | input | 1 | Stop condition seen on the bus |
| nack_addr | input | 1 | NACK received after the address byte |
| nack_data | input | 1 | NACK received after a written data byte |
| arb_lost | input | 1 | Master lost bus arbitration |
| xfer_done | input | 1 | Transfer with the addressed slave finished |
| rx_push | input | 1 | Byte written into the receive FIFO |
| rx_full | input | 1 | Receive FIFO full before this push |
| eng_active | input | 1 | Master engine is working on a transaction |
| addr_wr_sent | input | 1 | Address with write direction has been sent |
| tx_level | input | LVL_W | Transmit FIFO occupancy, 0 to TX_DEPTH |
| done_clr | input | 1 | Write-one-to-clear strobe for transfer complete |
| irq_en | input | 5 | Per-source interrupt enables |
| rd_en | input | 1 | Read strobe for the status word |
| rd_data | output | 16 | Registered status word |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check that the reserved bits and the 10 level code never appear, and how bus busy follows start and stop. They also check that overflow tracks a push into a full FIFO, that transfer complete stays set until cleared, and that an enabled arbitration loss reaches irq. The arming sequence for the transmit request needs the bench's scenarios: an address-plus-write followed by level changes, and disarming by stop or start. So do the clear-versus-set collision, the read hold while rd_en is low, and the irq masking across enable patterns.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;
  localparam int STAT_W    = 16;
  localparam int RSVD_LO   = 11;
  localparam int B_BUSBUSY = 10;
  localparam int B_RXOVF   = 9;
  localparam int B_DONE    = 8;
  localparam int B_DNACK   = 7;
  localparam int B_MBUSY   = 6;
  localparam int B_ARB     = 5;
  localparam int B_ANACK   = 4;
  localparam int B_RXREQ   = 3;
  localparam int B_TXREQ   = 2;
  localparam int LVL_CODE_W = 2;

  localparam int IE_W    = 5;
  localparam int IE_DONE = 0;
  localparam int IE_NACK = 1;
  localparam int IE_ARB  = 2;
  localparam int IE_RX   = 3;
  localparam int IE_TX   = 4;

  // one-cycle event bits and where they land in the word
  localparam int NPULSE = 5;
  localparam int PULSE_POS [NPULSE] = '{B_RXOVF, B_DNACK, B_ARB, B_ANACK, B_RXREQ};

  typedef enum logic [LVL_CODE_W-1:0] {
    LVL_EMPTY = 2'b00,
    LVL_PART  = 2'b01,
    LVL_FULL  = 2'b11
  } lvl_code_e;
endpackage

// File: rtl/i2cm_evt_bits.sv
module i2cm_evt_bits
  import i2cm_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              nack_addr,
  input  logic              nack_data,
  input  logic              arb_lost,
  input  logic              xfer_done,
  input  logic              rx_push,
  input  logic              rx_full,
  input  logic              eng_active,
  input  logic              done_clr,
  output logic [STAT_W-1:0] evt_bits
);
  logic [NPULSE-1:0] pulse_in;
  logic [NPULSE-1:0] pulse_q;
  logic              busbusy_q;
  logic              done_q;
  logic              mbusy_q;

  // order matches PULSE_POS
  assign pulse_in = {rx_push, nack_addr, arb_lost, nack_data, rx_push & rx_full};

  genvar g;
  generate
    for (g = 0; g < NPULSE; g++) begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) pulse_q[g] <= 1'b0;
        else     pulse_q[g] <= pulse_in[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busbusy_q <= 1'b0;
      done_q    <= 1'b0;
      mbusy_q   <= 1'b0;
    end else begin
      if (start_det)     busbusy_q <= 1'b1;
      else if (stop_det) busbusy_q <= 1'b0;

      if (xfer_done)     done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;

      mbusy_q <= eng_active & ~arb_lost;
    end
  end

  always_comb begin
    evt_bits = '0;
    for (int i = 0; i < NPULSE; i++) evt_bits[PULSE_POS[i]] = pulse_q[i];
    evt_bits[B_BUSBUSY] = busbusy_q;
    evt_bits[B_DONE]    = done_q;
    evt_bits[B_MBUSY]   = mbusy_q;
  end
endmodule

// File: rtl/i2cm_tx_track.sv
module i2cm_tx_track
  import i2cm_stat_pkg::*;
#(
  parameter int TX_DEPTH = 2,
  parameter int LVL_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_det,
  input  logic                  stop_det,
  input  logic                  addr_wr_sent,
  input  logic [LVL_W-1:0]      tx_level,
  output logic                  tx_req,
  output logic [LVL_CODE_W-1:0] lvl_code
);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(TX_DEPTH);

  logic      armed_q;
  lvl_code_e code_d;

  always_comb begin
    if (tx_level == '0)           code_d = LVL_EMPTY;
    else if (tx_level >= LVL_TOP) code_d = LVL_FULL;
    else                          code_d = LVL_PART;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      tx_req   <= 1'b0;
      lvl_code <= LVL_EMPTY;
    end else begin
      if (addr_wr_sent)              armed_q <= 1'b1;
      else if (start_det | stop_det) armed_q <= 1'b0;
      tx_req   <= armed_q & (tx_level <= LVL_ONE);
      lvl_code <= code_d;
    end
  end
endmodule

// File: rtl/i2cm_irq_read.sv
module i2cm_irq_read
  import i2cm_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic [IE_W-1:0]   irq_en,
  input  logic              rd_en,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);
  logic [IE_W-1:0] src;

  always_comb begin
    src          = '0;
    src[IE_DONE] = stat[B_DONE];
    src[IE_NACK] = stat[B_DNACK] | stat[B_ANACK];
    src[IE_ARB]  = stat[B_ARB];
    src[IE_RX]   = stat[B_RXREQ];
    src[IE_TX]   = stat[B_TXREQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= stat;
      irq <= |(src & irq_en);
    end
  end
endmodule

// File: rtl/i2cm_status_unit.sv
module i2cm_status_unit
  import i2cm_stat_pkg::*;
#(
  parameter int TX_DEPTH = 2,
  parameter int LVL_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              nack_addr,
  input  logic              nack_data,
  input  logic              arb_lost,
  input  logic              xfer_done,
  input  logic              rx_push,
  input  logic              rx_full,
  input  logic              eng_active,
  input  logic              addr_wr_sent,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              done_clr,
  input  logic [IE_W-1:0]   irq_en,
  input  logic              rd_en,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);
  logic [STAT_W-1:0]     evt_bits;
  logic [STAT_W-1:0]     stat_w;
  logic                  tx_req;
  logic [LVL_CODE_W-1:0] lvl_code;

  i2cm_evt_bits u_evt (
    .clk        (clk),
    .rst        (rst),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .nack_addr  (nack_addr),
    .nack_data  (nack_data),
    .arb_lost   (arb_lost),
    .xfer_done  (xfer_done),
    .rx_push    (rx_push),
    .rx_full    (rx_full),
    .eng_active (eng_active),
    .done_clr   (done_clr),
    .evt_bits   (evt_bits)
  );

  i2cm_tx_track #(.TX_DEPTH(TX_DEPTH), .LVL_W(LVL_W)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .addr_wr_sent (addr_wr_sent),
    .tx_level     (tx_level),
    .tx_req       (tx_req),
    .lvl_code     (lvl_code)
  );

  always_comb begin
    stat_w = evt_bits;
    stat_w[B_TXREQ] = tx_req;
    stat_w[LVL_CODE_W-1:0] = lvl_code;
  end

  i2cm_irq_read u_out (
    .clk     (clk),
    .rst     (rst),
    .stat    (stat_w),
    .irq_en  (irq_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq     (irq)
  );
endmodule

// File: rtl/i2cm_status_chk.sv
module i2cm_status_chk
  import i2cm_stat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start_det,
  input logic              stop_det,
  input logic              rx_push,
  input logic              rx_full,
  input logic              xfer_done,
  input logic              done_clr,
  input logic [IE_W-1:0]   irq_en,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] rd_data,
  input logic              irq
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rd_data[STAT_W-1:RSVD_LO] == '0);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && !irq);

  p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> stat[B_BUSBUSY]);

  p_busy_stop_r2: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> !stat[B_BUSBUSY]);

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> stat[B_RXOVF]);

  p_ovf_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !(rx_push && rx_full) |=> !stat[B_RXOVF]);

  p_done_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (stat[B_DONE] && !done_clr) |=> stat[B_DONE]);

  p_done_set_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> stat[B_DONE]);

  p_no_code10_r10: assert property (@(posedge clk) disable iff (rst)
    stat[1:0] != 2'b10);

  p_arb_irq_r11: assert property (@(posedge clk) disable iff (rst)
    (stat[B_ARB] && irq_en[IE_ARB]) |=> irq);
endmodule

bind i2cm_status_unit i2cm_status_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_det (start_det),
  .stop_det  (stop_det),
  .rx_push   (rx_push),
  .rx_full   (rx_full),
  .xfer_done (xfer_done),
  .done_clr  (done_clr),
  .irq_en    (irq_en),
  .stat      (stat_w),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/i2cm_status_unit_bench.sv
`timescale 1ns/1ps
module i2cm_status_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_det = 0, stop_det = 0, nack_addr = 0, nack_data = 0, arb_lost = 0;
  logic xfer_done = 0, rx_push = 0, rx_full = 0, eng_active = 0, addr_wr_sent = 0;
  logic [1:0] tx_level = 0;
  logic done_clr = 0;
  logic [4:0] irq_en = 0;
  logic rd_en = 1;
  logic [15:0] rd_data;
  logic irq;

  int vectors = 0;
  int miscompares = 0;
  logic [17:0] expq [$];
  logic [15:0] m_stat = 0;
  logic [15:0] m_rd = 0;
  logic m_armed = 0;

  always #4 clk = ~clk;

  i2cm_status_unit u_i2cm_status_unit (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .nack_addr(nack_addr), .nack_data(nack_data), .arb_lost(arb_lost),
    .xfer_done(xfer_done), .rx_push(rx_push), .rx_full(rx_full),
    .eng_active(eng_active), .addr_wr_sent(addr_wr_sent), .tx_level(tx_level),
    .done_clr(done_clr), .irq_en(irq_en), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic string req_of(int b);
    if (b == 16) return "R11";
    if (b >= 11) return "R1";
    case (b)
      10: return "R2";
      9: return "R3";
      8: return "R4";
      7, 4: return "R5";
      6: return "R6";
      5: return "R7";
      3: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic irq_of(logic [15:0] s, logic [4:0] en);
    return (en[0] & s[8]) | (en[1] & (s[7] | s[4])) | (en[2] & s[5]) |
           (en[3] & s[3]) | (en[4] & s[2]);
  endfunction

  // driver: called at a falling edge with inputs already set
  task automatic tick();
    logic [15:0] s;
    logic [15:0] exp_rd;
    exp_rd = rd_en ? m_stat : m_rd;
    expq.push_back({!rd_en, irq_of(m_stat, irq_en), exp_rd});
    m_rd = exp_rd;
    s = 16'h0;
    s[10] = start_det ? 1'b1 : (stop_det ? 1'b0 : m_stat[10]);
    s[9] = rx_push & rx_full;
    s[8] = xfer_done ? 1'b1 : (done_clr ? 1'b0 : m_stat[8]);
    s[7] = nack_data;
    s[6] = eng_active & ~arb_lost;
    s[5] = arb_lost;
    s[4] = nack_addr;
    s[3] = rx_push;
    s[2] = m_armed && (tx_level <= 2'd1);
    s[1:0] = (tx_level == 0) ? 2'b00 : ((tx_level >= 2) ? 2'b11 : 2'b01);
    m_armed = addr_wr_sent ? 1'b1 : ((start_det | stop_det) ? 1'b0 : m_armed);
    m_stat = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    start_det = 0; stop_det = 0; nack_addr = 0; nack_data = 0; arb_lost = 0;
    xfer_done = 0; rx_push = 0; rx_full = 0; addr_wr_sent = 0; done_clr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin clear_strobes(); tick(); end
  endtask

  // monitor: compares one queued item per cycle, after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        logic [17:0] e;
        logic [16:0] act;
        e = expq.pop_front();
        act = {irq, rd_data};
        vectors++;
        if (act !== e[16:0]) begin
          miscompares++;
          for (int b = 0; b < 17; b++)
            if (act[b] !== e[b])
              $display("FAIL %s%s bit %0d: actual %0h expected %0h (word %h vs %h)",
                       req_of(b), e[17] ? "/R12" : "", b, act[b], e[b], act, e[16:0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    vectors++;
    if (rd_data !== 16'h0 || irq !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: actual %h/%b expected 0000/0", rd_data, irq);
    end
    idle(2);
    // R2: start, hold, stop, start+stop together
    start_det = 1; tick(); idle(3);
    stop_det = 1; tick(); idle(2);
    start_det = 1; stop_det = 1; tick(); idle(2);
    stop_det = 1; tick(); idle(1);
    // R3, R8: pushes into non-full and full receive FIFO
    rx_push = 1; tick();
    rx_push = 1; rx_full = 1; tick();
    rx_full = 1; tick(); idle(2);
    // R11: receive request interrupt enabled
    irq_en = 5'b01000; rx_push = 1; tick(); idle(3); irq_en = 0; idle(1);
    // R4: sticky done, clear, collision set+clear
    xfer_done = 1; tick(); idle(3);
    irq_en = 5'b00001; idle(2);
    done_clr = 1; tick(); idle(2);
    xfer_done = 1; done_clr = 1; tick(); idle(2);
    done_clr = 1; tick(); irq_en = 0; idle(1);
    // R5, R11: NACK bits with and without the shared enable
    nack_addr = 1; tick(); nack_data = 1; tick(); idle(2);
    irq_en = 5'b00010; nack_data = 1; tick(); idle(1); nack_addr = 1; tick(); idle(2);
    irq_en = 5'b11101; nack_addr = 1; tick(); idle(2); irq_en = 0;
    // R6, R7: engine activity and arbitration loss
    eng_active = 1; idle(3);
    arb_lost = 1; tick(); idle(2);
    irq_en = 5'b00100; arb_lost = 1; tick(); idle(2);
    eng_active = 0; irq_en = 0; idle(2);
    // R9, R10: level codes before arming, then armed
    for (int l = 0; l < 3; l++) begin tx_level = 2'(l); idle(2); end
    tx_level = 2; addr_wr_sent = 1; tick(); idle(2);
    tx_level = 1; idle(2);
    tx_level = 0; irq_en = 5'b10000; idle(2);
    tx_level = 2; idle(2);
    tx_level = 1; stop_det = 1; tick(); idle(2);
    // R9: arm wins over start in same cycle, then start disarms
    addr_wr_sent = 1; start_det = 1; tick(); idle(2);
    start_det = 1; tick(); idle(2);
    irq_en = 0; tx_level = 0; idle(1);
    // R12: read hold while rd_en low
    rd_en = 0; start_det = 1; tick(); xfer_done = 1; tick(); idle(3);
    rd_en = 1; idle(2);
    stop_det = 1; done_clr = 1; tick(); idle(3);
    repeat (2) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule